// File: doc/BRIEF.md
# Boot Sector Write-Lockout Controller

This block sits between a flash-style memory's command decoder and its embedded program/erase engine. The decoder presents already-decoded single-cycle strobes: word program, sector erase, chip erase, lock set, ID-mode entry and ID-mode exit. Each strobe comes with a 17-bit word address. The controller decides for each array request whether it may proceed. For an erase it also says which sectors the engine is allowed to clear.

The lowest 8K words form a protected boot sector. A one-way lock flag can be set by command, and only a power-on clear resets it. While the flag is set, program and sector-erase requests aimed at the boot sector are refused. A chip erase then spares the boot sector. A high-voltage override input, held for the duration of the request, suspends the lock. In ID mode, the address bus selects identification words, and one of them reports the lock state.

Top module: `boot_lock_ctrl`

## Requirements
- R1: Address decode for erase: words 0x00000–0x01FFF are the boot sector (mask bit 0), 0x02000–0x02FFF parameter sector A (bit 1), 0x03000–0x03FFF parameter sector B (bit 2), and 0x04000–0x1FFFF the main array (bit 3). A granted sector erase drives exactly the target's bit on `erase_mask_o`.
- R2: With the lock clear, every program and sector-erase request is granted. `grant_o` pulses high for one cycle in the clock cycle after the strobe. A program grant carries `erase_mask_o` = 0.
- R3: With the lock set and the override low, a program or sector erase aimed at the boot sector raises `denied_o` for one cycle in the cycle after the strobe. In that case `grant_o` stays low and `erase_mask_o` stays 0.
- R4: With the lock set, program and sector-erase requests outside the boot sector are still granted.
- R5: A chip erase is always granted. Its mask is 4'b1111 with the lock clear, or with the override high. It is 4'b1110 with the lock set and the override low.
- R6: With `hv_override_i` high in the strobe cycle, boot-sector requests are granted despite the lock. Once the override is low again, refusals resume.
- R7: In ID mode, address 0 reads 0x001F and address 1 reads 0x0082. Any address other than 0, 1 and 2 reads 0x0000. Outside ID mode, `id_data_o` is 0x0000. `id_enter_i` sets ID mode and `id_exit_i` clears it, effective from the next cycle.
- R8: In ID mode, address 2 reads the lock state on bit 0 (1 = locked, 0 = programmable), with all other bits 0.
- R9: `lock_set_i` sets the lock from the next cycle. No strobe clears it, and a lock-set strobe produces neither a grant nor a refusal.
- R10: `rst_ni` low clears the pulses, the mask and ID mode, but keeps the lock. `por_ni` low clears the lock and all other state.
- R11: `grant_o` and `denied_o` are never high together. Each strobe yields at most one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Functional reset, asynchronous, active low |
| por_ni | input | 1 | Power-on clear, asynchronous, active low |
| prog_req_i | input | 1 | Word program strobe |
| sect_erase_req_i | input | 1 | Sector erase strobe |
| chip_erase_req_i | input | 1 | Chip erase strobe |
| lock_set_i | input | 1 | Lock-set strobe |
| id_enter_i | input | 1 | ID-mode entry strobe |
| id_exit_i | input | 1 | ID-mode exit strobe |
| addr_i | input | 17 | Word address for requests and ID reads |
| hv_override_i | input | 1 | Lock override, high while the override voltage is present |
| grant_o | output | 1 | One-cycle permit pulse |
| denied_o | output | 1 | One-cycle refusal pulse |
| erase_mask_o | output | 4 | Sectors the engine may erase, valid with `grant_o` |
| id_mode_o | output | 1 | ID mode active |
| id_data_o | output | 16 | ID-mode read data |

## Verification
The assertions assume that the decoder raises at most one strobe per cycle. They also assume that no strobe arrives while either reset is low. The bench issues each command as an isolated one-cycle strobe followed by an idle cycle, and it holds every strobe low around both resets. The override is changed only between commands, so it is steady across each request.

// File: rtl/boot_lock_pkg.sv
package boot_lock_pkg;
  localparam int NUM_SECT  = 4;
  localparam int SECT_BOOT = 0;
  localparam int SECT_PA   = 1;
  localparam int SECT_PB   = 2;
  localparam int SECT_MAIN = 3;
  typedef logic [NUM_SECT-1:0] sect_mask_t;
endpackage

// File: rtl/boot_lock_sector_dec.sv
module boot_lock_sector_dec
  import boot_lock_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter logic [ADDR_W-1:0] BOOT_LAST = 17'h01FFF,
  parameter logic [ADDR_W-1:0] PA_LAST   = 17'h02FFF,
  parameter logic [ADDR_W-1:0] PB_LAST   = 17'h03FFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sect_mask_t        hit_o
);
  localparam logic [NUM_SECT-1:0][ADDR_W-1:0] LO =
    {PB_LAST + 1'b1, PA_LAST + 1'b1, BOOT_LAST + 1'b1, {ADDR_W{1'b0}}};
  localparam logic [NUM_SECT-1:0][ADDR_W-1:0] HI =
    {{ADDR_W{1'b1}}, PB_LAST, PA_LAST, BOOT_LAST};

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
    assign hit_o[i] = (addr_i >= LO[i]) && (addr_i <= HI[i]);
  end

  always_comb begin
    a_r1_one_sector: assert ($onehot(hit_o));
  end
endmodule

// File: rtl/boot_lock_flag.sv
module boot_lock_flag (
  input  logic clk_i,
  input  logic por_ni,
  input  logic set_i,
  output logic lock_o
);
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)    lock_o <= 1'b0;
    else if (set_i) lock_o <= 1'b1;
  end

  a_r9_lock_sticky: assert property (@(posedge clk_i) disable iff (!por_ni)
    lock_o |=> lock_o);
  a_r9_set_takes: assert property (@(posedge clk_i) disable iff (!por_ni)
    set_i |=> lock_o);
endmodule

// File: rtl/boot_lock_id_read.sv
module boot_lock_id_read #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h001F,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h0082,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 17'h00002
) (
  input  logic              id_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              locked_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    if (id_mode_i) begin
      if (addr_i == '0)                       data_o = MFR_CODE;
      else if (addr_i == {{ADDR_W-1{1'b0}}, 1'b1}) data_o = DEV_CODE;
      else if (addr_i == LOCK_ADDR)           data_o = {{DATA_W-1{1'b0}}, locked_i};
    end
  end
endmodule

// File: rtl/boot_lock_ctrl.sv
module boot_lock_ctrl
  import boot_lock_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] BOOT_LAST = 17'h01FFF,
  parameter logic [ADDR_W-1:0] PA_LAST   = 17'h02FFF,
  parameter logic [ADDR_W-1:0] PB_LAST   = 17'h03FFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              prog_req_i,
  input  logic              sect_erase_req_i,
  input  logic              chip_erase_req_i,
  input  logic              lock_set_i,
  input  logic              id_enter_i,
  input  logic              id_exit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hv_override_i,
  output logic              grant_o,
  output logic              denied_o,
  output logic [NUM_SECT-1:0] erase_mask_o,
  output logic              id_mode_o,
  output logic [DATA_W-1:0] id_data_o
);
  sect_mask_t hit;
  logic       lock_q;
  logic       guard, blocked, array_req;
  sect_mask_t chip_mask, mask_d;
  logic       rst_all_n;

  assign rst_all_n = rst_ni & por_ni;

  boot_lock_sector_dec #(
    .ADDR_W(ADDR_W), .BOOT_LAST(BOOT_LAST), .PA_LAST(PA_LAST), .PB_LAST(PB_LAST)
  ) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  boot_lock_flag u_flag (
    .clk_i  (clk_i),
    .por_ni (por_ni),
    .set_i  (lock_set_i),
    .lock_o (lock_q)
  );

  boot_lock_id_read #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_id (
    .id_mode_i (id_mode_o),
    .addr_i    (addr_i),
    .locked_i  (lock_q),
    .data_o    (id_data_o)
  );

  // lock is honoured only without override
  assign guard     = lock_q & ~hv_override_i;
  assign blocked   = guard & hit[SECT_BOOT] & (prog_req_i | sect_erase_req_i);
  assign array_req = prog_req_i | sect_erase_req_i | chip_erase_req_i;

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_chip
    if (i == SECT_BOOT) begin : g_boot
      assign chip_mask[i] = ~guard;
    end else begin : g_other
      assign chip_mask[i] = 1'b1;
    end
  end

  always_comb begin
    mask_d = '0;
    if (sect_erase_req_i && !blocked) mask_d = hit;
    else if (chip_erase_req_i)        mask_d = chip_mask;
  end

  always_ff @(posedge clk_i or negedge rst_all_n) begin
    if (!rst_all_n) begin
      grant_o      <= 1'b0;
      denied_o     <= 1'b0;
      erase_mask_o <= '0;
      id_mode_o    <= 1'b0;
    end else begin
      grant_o      <= array_req & ~blocked;
      denied_o     <= blocked;
      erase_mask_o <= mask_d;
      if (id_enter_i)     id_mode_o <= 1'b1;
      else if (id_exit_i) id_mode_o <= 1'b0;
    end
  end

  a_r11_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    $onehot0({prog_req_i, sect_erase_req_i, chip_erase_req_i, lock_set_i, id_enter_i, id_exit_i}));
  a_r11_grant_deny_excl: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    !(grant_o && denied_o));
  a_r3_deny_no_mask: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    denied_o |-> (erase_mask_o == '0));
  a_r3_boot_refused: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    (prog_req_i && lock_q && !hv_override_i && addr_i <= BOOT_LAST) |=> (denied_o && !grant_o));
  a_r5_chip_spares_boot: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    (chip_erase_req_i && lock_q && !hv_override_i) |=> (grant_o && erase_mask_o == 4'b1110));
  a_r6_override_grants: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    ((prog_req_i || sect_erase_req_i) && hv_override_i) |=> (grant_o && !denied_o));
  a_r2_prog_no_mask: assert property (@(posedge clk_i) disable iff (!rst_all_n)
    prog_req_i |=> (erase_mask_o == '0));
endmodule

// File: tb/boot_lock_ctrl_bench.sv
module boot_lock_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic prog = 0, serase = 0, cerase = 0, lset = 0, iden = 0, idex = 0;
  logic [16:0] addr = '0;
  logic hv = 0;
  logic grant, denied, id_mode;
  logic [3:0] mask;
  logic [15:0] id_data;

  int vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R10";

  // reference state
  logic m_lock = 0, m_grant = 0, m_deny = 0, m_idm = 0;
  logic [3:0] m_mask = 0;

  always #2.5 clk = ~clk;

  boot_lock_ctrl u_boot_lock_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n),
    .prog_req_i(prog), .sect_erase_req_i(serase), .chip_erase_req_i(cerase),
    .lock_set_i(lset), .id_enter_i(iden), .id_exit_i(idex),
    .addr_i(addr), .hv_override_i(hv),
    .grant_o(grant), .denied_o(denied), .erase_mask_o(mask),
    .id_mode_o(id_mode), .id_data_o(id_data)
  );

  function automatic logic [3:0] sect_of(input logic [16:0] a);
    if (a < 17'h02000)      return 4'b0001;
    else if (a < 17'h03000) return 4'b0010;
    else if (a < 17'h04000) return 4'b0100;
    else                    return 4'b1000;
  endfunction

  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n) begin
      m_lock = 0; m_grant = 0; m_deny = 0; m_mask = 0; m_idm = 0;
    end else if (!rst_n) begin
      m_grant = 0; m_deny = 0; m_mask = 0; m_idm = 0;
    end else begin
      logic protect, refuse;
      protect = m_lock && !hv;
      refuse  = protect && (prog || serase) && sect_of(addr) == 4'b0001;
      m_deny  = refuse;
      m_grant = (prog || serase || cerase) && !refuse;
      m_mask  = 4'b0000;
      if (serase && !refuse) m_mask = sect_of(addr);
      if (cerase)            m_mask = protect ? 4'b1110 : 4'b1111;
      if (iden) m_idm = 1; else if (idex) m_idm = 0;
      if (lset) m_lock = 1;
    end
  end

  function automatic logic [15:0] exp_id();
    if (!m_idm) return 16'h0000;
    if (addr == 0) return 16'h001F;
    if (addr == 1) return 16'h0082;
    if (addr == 2) return {15'b0, m_lock};
    return 16'h0000;
  endfunction

  task automatic cmp(input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cycles++;
    cmp("grant", {15'b0, grant}, {15'b0, m_grant});
    cmp("denied", {15'b0, denied}, {15'b0, m_deny});
    cmp("mask", {12'b0, mask}, {12'b0, m_mask});
    cmp("id_mode", {15'b0, id_mode}, {15'b0, m_idm});
    cmp("id_data", id_data, exp_id());
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 prog, 1 sector erase, 2 chip erase, 3 lock, 4 id enter, 5 id exit
  task automatic cmd(input int kind, input logic [16:0] a);
    @(negedge clk);
    addr = a;
    prog = (kind == 0); serase = (kind == 1); cerase = (kind == 2);
    lset = (kind == 3); iden = (kind == 4); idex = (kind == 5);
    @(negedge clk);
    prog = 0; serase = 0; cerase = 0; lset = 0; iden = 0; idex = 0;
    idle(1);
  endtask

  task automatic rd(input logic [16:0] a);
    @(negedge clk);
    addr = a;
    idle(1);
  endtask

  initial begin
    idle(3);
    por_n = 1; rst_n = 1;
    idle(2);
    cur_req = "R2";
    cmd(0, 17'h00100); cmd(0, 17'h02500); cmd(0, 17'h1FFFF);
    cur_req = "R1";
    cmd(1, 17'h01FFF); cmd(1, 17'h02000); cmd(1, 17'h02FFF); cmd(1, 17'h03000);
    cmd(1, 17'h03FFF); cmd(1, 17'h04000); cmd(1, 17'h1FFFF); cmd(1, 17'h00000);
    cur_req = "R5";
    cmd(2, 17'h05555);
    cur_req = "R7";
    rd(17'h00000);
    cmd(4, 17'h05555);
    rd(17'h00000); rd(17'h00001); rd(17'h00003); rd(17'h1FFFF);
    cur_req = "R8";
    rd(17'h00002);
    cur_req = "R7";
    cmd(5, 17'h00000);
    rd(17'h00001);
    cur_req = "R9";
    cmd(3, 17'h05555);
    cmd(4, 17'h05555);
    cur_req = "R8";
    rd(17'h00002);
    cur_req = "R9";
    cmd(5, 17'h00000); cmd(4, 17'h00000);
    rd(17'h00002);
    cmd(5, 17'h00000); cmd(3, 17'h00000);
    cur_req = "R3";
    cmd(0, 17'h00000); cmd(0, 17'h01FFF); cmd(1, 17'h00123); cmd(1, 17'h01FFF);
    cur_req = "R4";
    cmd(0, 17'h02000); cmd(1, 17'h03000); cmd(1, 17'h1F000); cmd(0, 17'h04000);
    cur_req = "R5";
    cmd(2, 17'h05555);
    cur_req = "R6";
    @(negedge clk); hv = 1;
    cmd(0, 17'h00010); cmd(1, 17'h00010); cmd(2, 17'h05555);
    @(negedge clk); hv = 0;
    cmd(0, 17'h00010); cmd(1, 17'h01000);
    cur_req = "R10";
    cmd(4, 17'h00000);
    @(negedge clk); rst_n = 0;
    idle(2);
    @(negedge clk); rst_n = 1;
    cmd(0, 17'h00020);
    cmd(4, 17'h00000);
    rd(17'h00002);
    @(negedge clk); por_n = 0;
    idle(2);
    @(negedge clk); por_n = 1;
    cmd(4, 17'h00000);
    rd(17'h00002);
    cmd(0, 17'h00020);
    cmd(2, 17'h05555);
    cur_req = "R11";
    @(negedge clk); hv = 1;
    idle(4);
    @(negedge clk); hv = 0;
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule